// File: doc/BRIEF.md
# Multi-Target Level Interrupt Router

This block collects up to 31 level-sensitive interrupt inputs and routes them to a set of target contexts, each with its own interrupt request line. Source position 0 is reserved and never becomes pending. A single pending vector is shared by all targets. Each target has its own enable word. A per-source in-service mask stops a source that is still held high from becoming pending again until its handler signals completion.

Software reaches the block through a 32-bit word register bus. The bus carries a valid strobe, a write flag, a byte address and write data. Every accepted request gets exactly one registered response on the following cycle, with read data and an error flag.

A target takes an interrupt by reading its claim word, which returns the highest-numbered source that is both pending and enabled for it. The target finishes by writing that source number back to the same word. There is no priority scheme. Priority words and the per-target threshold word are present only so that software finds them; they hold nothing. Source inputs are expected to be synchronous to the block clock.

Top module: `irq_hub`

## Requirements
- R1: After reset the pending vector, every in-service bit and every enable word are zero, all `irq` lines are low and `rsp_valid` is low.
- R2: Each request with `req_valid` high gets exactly one response, with `rsp_valid` high on the next cycle. `rsp_err` is set, with data 0, in these cases: a misaligned address, any address outside the map, a context index at or above NCTX, or a write to the pending word. Write responses carry data 0.
- R3: When a source input i (1 to 31) is high and its in-service bit is clear, pending bit i and in-service bit i are set at the next clock edge. The pending vector reads at byte 0x001000 with bit i standing for source i. Input 0 never pends.
- R4: A source held high does not become pending again until its in-service bit has been cleared by a completion.
- R5: The enable word of context N sits at byte 0x002000 + 0x80*N. Bit i of that word enables source i. Bit 0 always reads 0 whatever was written.
- R6: `irq[N]` is high exactly while the pending vector ANDed with context N's enable word is nonzero. It follows the same clock edge that changes either of them.
- R7: A read of byte 0x200004 + 0x1000*N returns the number of the highest-numbered source that is pending and enabled for context N, and clears that pending bit. If no such source exists, the read returns 0.
- R8: A write of value v to byte 0x200004 + 0x1000*N clears in-service bit v only when v is below 32 and bit v of context N's enable word is set. Otherwise the write changes nothing. A source still held high after completion pends again one cycle later.
- R9: Priority words at bytes 0x000004 to 0x00007C and the threshold word at 0x200000 + 0x1000*N read as 0, and writes to them have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_lvl | input | 32 | Level interrupt inputs, bit i is source i (bit 0 unused) |
| req_valid | input | 1 | Bus request strobe |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_rdata | output | 32 | Read data |
| rsp_err | output | 1 | Access error |
| irq | output | NCTX | One interrupt request per context |

## Verification
A stuck or lost in-service bit shows up at the ports within a few cycles. If a held source loses its mask, the pending vector, or a second claim, shows a source the target already took. If a bit sticks, a source never pends again after completion, and its `irq` line stays low. A wrong claim choice or a missed pending clear shows up in the very next claim read, because that read returns the wrong number or the same number twice. A completion gate that ignores the enable word lets a non-enabled context re-arm a source, and the pending vector shows this one cycle later.

// File: rtl/irqh_pkg.sv
package irqh_pkg;

  localparam int SRC_N = 32;
  localparam int ID_W  = 5;

  localparam logic [31:0] PRIO_END   = 32'h0000_0080;
  localparam logic [31:0] PEND_ADDR  = 32'h0000_1000;
  localparam logic [31:0] EN_BASE    = 32'h0000_2000;
  localparam int          EN_SHIFT   = 7;
  localparam logic [31:0] CTX_BASE   = 32'h0020_0000;
  localparam int          CTX_SHIFT  = 12;

  typedef enum logic [2:0] {
    RK_NONE,
    RK_PRIO,
    RK_PEND,
    RK_EN,
    RK_THR,
    RK_CLAIM
  } reg_kind_e;

  // highest set bit position; 0 when the vector is empty
  function automatic logic [ID_W-1:0] top_id(input logic [SRC_N-1:0] v);
    logic [ID_W-1:0] r;
    r = '0;
    for (int i = 1; i < SRC_N; i++) begin
      if (v[i]) r = ID_W'(i);
    end
    return r;
  endfunction

endpackage

// File: rtl/irqh_decode.sv
module irqh_decode
  import irqh_pkg::*;
#(
  parameter int NCTX   = 32,
  parameter int ADDR_W = 24,
  parameter int CTX_W  = 5
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              is_write,
  output reg_kind_e         kind,
  output logic [CTX_W-1:0]  ctx,
  output logic              err
);

  logic [31:0] a;
  logic [31:0] en_off;
  logic [31:0] cx_off;

  always_comb begin
    a = '0;
    a[ADDR_W-1:0] = addr;
    en_off = a - EN_BASE;
    cx_off = a - CTX_BASE;
    kind   = RK_NONE;
    ctx    = '0;
    if (a[1:0] != 2'b00) begin
      kind = RK_NONE;
    end else if (a != 32'd0 && a < PRIO_END) begin
      kind = RK_PRIO;
    end else if (a == PEND_ADDR) begin
      kind = is_write ? RK_NONE : RK_PEND;
    end else if (a >= EN_BASE && (en_off >> EN_SHIFT) < 32'(NCTX)
                 && en_off[EN_SHIFT-1:0] == '0) begin
      kind = RK_EN;
      ctx  = en_off[EN_SHIFT +: CTX_W];
    end else if (a >= CTX_BASE && (cx_off >> CTX_SHIFT) < 32'(NCTX)
                 && cx_off[CTX_SHIFT-1:3] == '0) begin
      kind = cx_off[2] ? RK_CLAIM : RK_THR;
      ctx  = cx_off[CTX_SHIFT +: CTX_W];
    end
    err = (kind == RK_NONE);
  end

endmodule

// File: rtl/irqh_gateway.sv
module irqh_gateway
  import irqh_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SRC_N-1:0] src,
  input  logic [SRC_N-1:0] clr_pend,
  input  logic [SRC_N-1:0] clr_svc,
  output logic [SRC_N-1:0] pend,
  output logic [SRC_N-1:0] insvc
);

  logic [SRC_N-1:0] pend_q, pend_d;
  logic [SRC_N-1:0] svc_q, svc_d;
  logic [SRC_N-1:0] take;

  always_comb begin
    // a new capture wins over a claim clear in the same cycle
    take   = src & ~svc_q & ~SRC_N'(1);
    pend_d = (pend_q & ~clr_pend) | take;
    svc_d  = (svc_q & ~clr_svc) | take;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      svc_q  <= '0;
    end else begin
      pend_q <= pend_d;
      svc_q  <= svc_d;
    end
  end

  assign pend  = pend_q;
  assign insvc = svc_q;

endmodule

// File: rtl/irqh_enables.sv
module irqh_enables
  import irqh_pkg::*;
#(
  parameter int NCTX  = 32,
  parameter int CTX_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_fire,
  input  logic [CTX_W-1:0] sel_ctx,
  input  logic [SRC_N-1:0] wr_data,
  input  logic [SRC_N-1:0] pend,
  output logic [SRC_N-1:0] en_sel,
  output logic [NCTX-1:0]  irq
);

  logic [SRC_N-1:0] en_bank [NCTX];

  for (genvar c = 0; c < NCTX; c++) begin : g_ctx
    logic [SRC_N-1:0] en_q, en_d;
    logic             hit;

    always_comb begin
      hit  = wr_fire && (int'(sel_ctx) == c);
      en_d = hit ? (wr_data & ~SRC_N'(1)) : en_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= '0;
      else        en_q <= en_d;
    end

    assign en_bank[c] = en_q;
    assign irq[c]     = |(pend & en_q);
  end

  always_comb begin
    if (int'(sel_ctx) < NCTX) en_sel = en_bank[sel_ctx];
    else                      en_sel = '0;
  end

endmodule

// File: rtl/irq_hub.sv
module irq_hub
  import irqh_pkg::*;
#(
  parameter int NCTX   = 32,
  parameter int ADDR_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [31:0]       src_lvl,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  output logic              rsp_valid,
  output logic [31:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [NCTX-1:0]   irq
);

  localparam int CTX_W = (NCTX > 1) ? $clog2(NCTX) : 1;

  // reset: asserted at once, released on the clock
  logic rst_m_n, rst_q_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m_n <= 1'b0;
      rst_q_n <= 1'b0;
    end else begin
      rst_m_n <= 1'b1;
      rst_q_n <= rst_m_n;
    end
  end

  reg_kind_e        kind;
  logic [CTX_W-1:0] ctx;
  logic             dec_err;

  irqh_decode #(.NCTX(NCTX), .ADDR_W(ADDR_W), .CTX_W(CTX_W)) u_dec (
    .addr     (req_addr),
    .is_write (req_write),
    .kind     (kind),
    .ctx      (ctx),
    .err      (dec_err)
  );

  logic             en_wr;
  logic [SRC_N-1:0] en_sel;
  logic [SRC_N-1:0] pend, insvc;
  logic [SRC_N-1:0] clr_pend, clr_svc;

  assign en_wr = req_valid && req_write && (kind == RK_EN);

  irqh_enables #(.NCTX(NCTX), .CTX_W(CTX_W)) u_en (
    .clk     (clk),
    .rst_n   (rst_q_n),
    .wr_fire (en_wr),
    .sel_ctx (ctx),
    .wr_data (req_wdata),
    .pend    (pend),
    .en_sel  (en_sel),
    .irq     (irq)
  );

  irqh_gateway u_gw (
    .clk      (clk),
    .rst_n    (rst_q_n),
    .src      (src_lvl),
    .clr_pend (clr_pend),
    .clr_svc  (clr_svc),
    .pend     (pend),
    .insvc    (insvc)
  );

  // claim arbitration and completion gating for the addressed context
  logic            claim_rd, done_wr;
  logic [ID_W-1:0] claim_id;
  logic [ID_W-1:0] done_id;
  logic            done_ok;

  always_comb begin
    claim_rd = req_valid && !req_write && (kind == RK_CLAIM);
    done_wr  = req_valid &&  req_write && (kind == RK_CLAIM);
    claim_id = top_id(pend & en_sel);
    done_id  = req_wdata[ID_W-1:0];
    done_ok  = done_wr && (req_wdata[31:ID_W] == '0) && en_sel[done_id];
    clr_pend = '0;
    clr_svc  = '0;
    if (claim_rd && claim_id != '0) clr_pend[claim_id] = 1'b1;
    if (done_ok)                    clr_svc[done_id]   = 1'b1;
  end

  // response
  logic        rv_d, re_d;
  logic [31:0] rd_d;

  always_comb begin
    rv_d = req_valid;
    re_d = req_valid && dec_err;
    rd_d = '0;
    if (req_valid && !req_write) begin
      unique case (kind)
        RK_PEND:  rd_d = pend;
        RK_EN:    rd_d = en_sel;
        RK_CLAIM: rd_d = 32'(claim_id);
        default:  rd_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      rsp_valid <= 1'b0;
      rsp_err   <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= rv_d;
      rsp_err   <= re_d;
      rsp_rdata <= rd_d;
    end
  end

endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int NCTX = 32
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_write,
  input logic [31:0]     src,
  input logic [31:0]     pend,
  input logic [31:0]     insvc,
  input logic [NCTX-1:0] irq,
  input logic            rsp_valid,
  input logic            rsp_err
);

  // R2
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // R2
  no_spurious_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !rsp_valid);

  // R2
  err_with_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> rsp_valid);

  // R3
  capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(src) & ~$past(insvc) & ~32'h1) & ~pend) == 32'h0));

  // R4
  no_repend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend & ~$past(pend) & $past(insvc)) == 32'h0));

  // R8
  svc_clear_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(insvc) & ~insvc) != 32'h0) |-> $past(req_valid && req_write));

  // R6
  irq_needs_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (irq != '0) |-> (pend != 32'h0));

  // R3
  src0_never_pends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pend[0]);

endmodule

bind irq_hub irq_hub_chk #(.NCTX(NCTX)) u_chk (
  .clk       (clk),
  .rst_n     (rst_q_n),
  .req_valid (req_valid),
  .req_write (req_write),
  .src       (src_lvl),
  .pend      (pend),
  .insvc     (insvc),
  .irq       (irq),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err)
);

// File: tb/sim_irq_hub.sv
`timescale 1ns/1ps
module sim_irq_hub;

  localparam int NCTX   = 32;
  localparam int ADDR_W = 24;

  logic              clk = 1'b0;
  logic              rst_n;
  logic [31:0]       src_lvl;
  logic              req_valid;
  logic              req_write;
  logic [ADDR_W-1:0] req_addr;
  logic [31:0]       req_wdata;
  logic              rsp_valid;
  logic [31:0]       rsp_rdata;
  logic              rsp_err;
  logic [NCTX-1:0]   irq;

  irq_hub #(.NCTX(NCTX), .ADDR_W(ADDR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .rsp_err(rsp_err),
    .irq(irq)
  );

  always #5 clk = ~clk;

  typedef struct {
    logic [31:0] data;
    logic        err;
    string       tag;
  } exp_t;

  exp_t sb[$];
  int   checks = 0;
  int   errors = 0;
  bit   done   = 1'b0;

  task automatic check(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // driver
  task automatic bus(logic wr, logic [31:0] addr, logic [31:0] wd,
                     logic [31:0] exp_d, logic exp_e, string tag);
    exp_t e;
    e.data = exp_d; e.err = exp_e; e.tag = tag;
    sb.push_back(e);
    @(posedge clk); #1;
    req_valid = 1'b1; req_write = wr;
    req_addr  = addr[ADDR_W-1:0]; req_wdata = wd;
    @(posedge clk); #1;
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic rd(logic [31:0] addr, logic [31:0] exp_d, string tag);
    bus(1'b0, addr, 32'h0, exp_d, 1'b0, tag);
  endtask

  task automatic wr(logic [31:0] addr, logic [31:0] d, string tag);
    bus(1'b1, addr, d, 32'h0, 1'b0, tag);
  endtask

  task automatic idle(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) begin
        checks++; errors++;
        $display("FAIL R2 unexpected response actual=1 expected=0");
      end else begin
        exp_t e;
        e = sb.pop_front();
        check({e.tag, " data"}, 64'(rsp_rdata), 64'(e.data));
        check({e.tag, " err"},  64'(rsp_err),   64'(e.err));
      end
    end
  end

  function automatic logic [31:0] en_a(int n);  return 32'h2000 + 32'(n) * 32'h80;  endfunction
  function automatic logic [31:0] thr_a(int n); return 32'h200000 + 32'(n) * 32'h1000; endfunction
  function automatic logic [31:0] clm_a(int n); return thr_a(n) + 32'h4; endfunction

  localparam logic [31:0] PEND = 32'h1000;

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; src_lvl = '0; req_valid = 1'b0; req_write = 1'b0;
    req_addr = '0; req_wdata = '0;
    idle(3);
    rst_n = 1'b1;
    idle(4);

    // R1 reset state
    @(negedge clk);
    check("R1 irq after reset", 64'(irq), 64'h0);
    check("R1 rsp_valid after reset", 64'(rsp_valid), 64'h0);
    rd(PEND, 32'h0, "R1 pending after reset");
    rd(en_a(0), 32'h0, "R1 enable ctx0 after reset");
    rd(en_a(31), 32'h0, "R1 enable ctx31 after reset");

    // R5 enables, bit 0 forced low
    wr(en_a(0), 32'hFFFF_FFFF, "R5 write en0");
    rd(en_a(0), 32'hFFFF_FFFE, "R5 en0 readback bit0 clear");
    wr(en_a(1), 32'h0000_0031, "R5 write en1");
    rd(en_a(1), 32'h0000_0030, "R5 en1 readback");

    // R3 capture, source 0 ignored
    src_lvl = 32'h0010_0089;
    idle(2);
    rd(PEND, 32'h0010_0088, "R3 pending after capture");
    @(negedge clk);
    check("R6 irq ctx0 high", 64'(irq[0]), 64'h1);
    check("R6 irq ctx1 low", 64'(irq[1]), 64'h0);
    check("R6 irq ctx2 low", 64'(irq[2]), 64'h0);

    // R7 claim order highest first, then 0
    rd(clm_a(0), 32'd20, "R7 claim ctx0 first");
    rd(clm_a(0), 32'd7,  "R7 claim ctx0 second");
    rd(clm_a(0), 32'd3,  "R7 claim ctx0 third");
    rd(clm_a(0), 32'd0,  "R7 claim ctx0 empty");
    @(negedge clk);
    check("R6 irq ctx0 low after claims", 64'(irq[0]), 64'h0);

    // R4 held sources stay quiet
    idle(5);
    rd(PEND, 32'h0, "R4 no re-pend while in service");

    // R8 completion gating
    wr(clm_a(1), 32'd7, "R8 complete from non-enabled ctx");
    idle(3);
    rd(PEND, 32'h0, "R8 non-enabled completion ignored");
    wr(clm_a(0), 32'd7, "R8 complete from ctx0");
    idle(1);
    rd(PEND, 32'h0000_0080, "R8 held source re-pends after completion");
    wr(clm_a(0), 32'd35, "R8 out of range id");
    idle(3);
    rd(PEND, 32'h0000_0080, "R8 out of range id ignored");

    // R6/R7 second context
    src_lvl = 32'h0010_0099;
    idle(2);
    @(negedge clk);
    check("R6 irq ctx1 high", 64'(irq[1]), 64'h1);
    rd(clm_a(1), 32'd4, "R7 claim ctx1 skips non-enabled");
    rd(clm_a(1), 32'd0, "R7 claim ctx1 empty");
    @(negedge clk);
    check("R6 irq ctx1 low", 64'(irq[1]), 64'h0);
    check("R6 irq ctx0 still high", 64'(irq[0]), 64'h1);
    rd(clm_a(0), 32'd7, "R7 claim ctx0 remaining");

    // R9 inert registers
    wr(32'h0000_000C, 32'h5, "R9 priority write");
    rd(32'h0000_000C, 32'h0, "R9 priority reads zero");
    wr(thr_a(0), 32'h7, "R9 threshold write");
    rd(thr_a(0), 32'h0, "R9 threshold reads zero");
    rd(en_a(0), 32'hFFFF_FFFE, "R9 enables untouched");

    // R2 access errors
    bus(1'b0, 32'h0000_0000, 32'h0, 32'h0, 1'b1, "R2 word 0 error");
    bus(1'b0, 32'h0000_2002, 32'h0, 32'h0, 1'b1, "R2 misaligned error");
    bus(1'b1, PEND, 32'hFFFF_FFFF, 32'h0, 1'b1, "R2 pending write error");
    bus(1'b0, en_a(NCTX), 32'h0, 32'h0, 1'b1, "R2 context beyond range");
    bus(1'b0, clm_a(NCTX), 32'h0, 32'h0, 1'b1, "R2 claim beyond range");
    bus(1'b0, 32'h0000_5000, 32'h0, 32'h0, 1'b1, "R2 hole error");
    bus(1'b0, 32'h0000_2004, 32'h0, 32'h0, 1'b1, "R2 inside enable stride");
    rd(PEND, 32'h0, "R2 pending unchanged by bad write");

    idle(3);
    check("R2 all responses seen", 64'(sb.size()), 64'h0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule